// File: doc/BRIEF.md
# Retire Counter CSR Access Unit

This unit keeps one 64-bit count that advances on a retire strobe. It serves the register-file accesses that touch that count: the machine-level low and high count addresses and the user-level cycle, time and instret aliases. It also holds two 32-bit counter-enable masks, one written at machine level and one at supervisor level. A read from a lower privilege level is allowed only when every mask that applies to that level has the selected bit set.

The hardware performance counter and event addresses are decoded so that they read as zero. Any access to an address the unit does not recognise, and any read that the masks block, comes back flagged as illegal. An illegal access changes no state.

The request side takes a valid strobe with a write flag, a 12-bit address and 64 bits of write data. It never applies back-pressure, so a request is accepted in every cycle its valid is high. The response is registered. It appears one cycle after acceptance as a valid pulse, with read data and an illegal flag. The privilege level and the 32-bit mode input are sampled together with the request.

Top module: `ctr_csr_unit`

## Requirements
- R1: Each cycle with `req_valid_i` high is accepted. Exactly one cycle later `rsp_valid_o` is high for one cycle, carrying that request's `rsp_rdata_o` and `rsp_illegal_o`. With no request, `rsp_valid_o` is low.
- R2: The count resets to zero. It advances by one on every clock edge where `retire_i` is high and no legal count write happens.
- R3: A legal write to the count in the same cycle as `retire_i` sets the count to the written value only; that cycle's increment is dropped.
- R4: Privilege codes are U=0, S=1 and M=3. The gate mask starts as all ones. It is ANDed with the machine enable mask when the privilege is below M, and also with the supervisor enable mask when the privilege is below S. The bit tested is address bits [4:0].
- R5: When the gate allows it, reads of 0xC00, 0xC01 and 0xC02 return the shared count. The full 64 bits are returned in 64-bit mode, and the low 32 bits zero-extended in 32-bit mode. A write to any address in 0xC00–0xC1F is illegal.
- R6: 0xB00 and 0xB02 read and write the count. In 32-bit mode a write to them replaces only bits [31:0]. In 64-bit mode it replaces all 64 bits. A write to 0xB80 or 0xB82, allowed only in 32-bit mode, replaces bits [63:32] with write data [31:0].
- R7: Reads of 0xB80, 0xB82 and the gated 0xC80–0xC82 return the count's bits [63:32], zero-extended. They are legal only in 32-bit mode and illegal in 64-bit mode.
- R8: The following addresses read as zero without an illegal flag:
  - 0xB03–0xB1F and the event selectors 0x323–0x33F;
  - 0xC03–0xC1F when the gate allows;
  - 0xB83–0xB9F and the gated 0xC83–0xC9F, in 32-bit mode only.
  Writes to the machine-level ones are accepted and change nothing.
- R9: The machine enable mask at 0x306 and the supervisor enable mask at 0x106 reset to zero. All 32 bits of each can be written and read back.
- R10: An access to an unrecognised address, or one blocked by the gate, gives `rsp_illegal_o`=1 with `rsp_rdata_o`=0 for one cycle, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One pulse per retired instruction |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Register address |
| req_wdata_i | input | 64 | Write data |
| priv_i | input | 2 | Current privilege level (U=0, S=1, M=3) |
| xlen32_i | input | 1 | 1 = 32-bit mode |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_illegal_o | output | 1 | Access was illegal |

## Verification
The hardest case to reach is a gate that blocks at user level but passes at supervisor level for the same address. It needs two different mask patterns loaded beforehand. The bench loads the machine mask with bits 0 and 2 and the supervisor mask with bit 0 only. It then reads the three user aliases from both levels, so each combination of set and clear bits is visited. Half-word writes are checked by preloading a 64-bit value in 64-bit mode and then rewriting each half in 32-bit mode. After each write the bench reads back both halves.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;
  localparam int ADDR_W = 12;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [ADDR_W-1:0] UCNT_LO_BASE = 12'hC00;
  localparam logic [ADDR_W-1:0] UCNT_HI_BASE = 12'hC80;
  localparam logic [ADDR_W-1:0] MCNT_LO_BASE = 12'hB00;
  localparam logic [ADDR_W-1:0] MCNT_HI_BASE = 12'hB80;
  localparam logic [ADDR_W-1:0] MEVT_BASE    = 12'h320;
  localparam logic [ADDR_W-1:0] MEN_ADDR     = 12'h306;
  localparam logic [ADDR_W-1:0] SEN_ADDR     = 12'h106;

  typedef enum logic [2:0] {
    K_BAD,
    K_CNT_LO,
    K_CNT_HI,
    K_ZERO,
    K_MEN,
    K_SEN
  } acc_kind_e;
endpackage

// File: rtl/ctr_csr_decode.sv
module ctr_csr_decode
  import ctr_csr_pkg::*;
#(
  parameter int EN_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [1:0]        priv_i,
  input  logic              xlen32_i,
  input  logic [EN_W-1:0]   men_i,
  input  logic [EN_W-1:0]   sen_i,
  output acc_kind_e         kind_o
);
  localparam int IDX_W = $clog2(EN_W);

  logic [EN_W-1:0]  gate;
  logic [IDX_W-1:0] idx;
  logic             ok, cnt_u, cnt_m, hpm;

  assign idx   = addr_i[IDX_W-1:0];
  assign cnt_u = (idx <= IDX_W'(2));
  assign cnt_m = (idx == IDX_W'(0)) || (idx == IDX_W'(2));
  assign hpm   = (idx >= IDX_W'(3));

  always_comb begin
    gate = '1;
    if (priv_i < PRIV_M) gate = gate & men_i;
    if (priv_i < PRIV_S) gate = gate & sen_i;
  end
  assign ok = gate[idx];

  always_comb begin
    kind_o = K_BAD;
    if (addr_i[ADDR_W-1:IDX_W] == UCNT_LO_BASE[ADDR_W-1:IDX_W]) begin
      if (ok && !write_i) kind_o = cnt_u ? K_CNT_LO : K_ZERO;
    end else if (addr_i[ADDR_W-1:IDX_W] == UCNT_HI_BASE[ADDR_W-1:IDX_W]) begin
      if (ok && !write_i && xlen32_i) kind_o = cnt_u ? K_CNT_HI : K_ZERO;
    end else if (addr_i[ADDR_W-1:IDX_W] == MCNT_LO_BASE[ADDR_W-1:IDX_W]) begin
      if (cnt_m)    kind_o = K_CNT_LO;
      else if (hpm) kind_o = K_ZERO;
    end else if (addr_i[ADDR_W-1:IDX_W] == MCNT_HI_BASE[ADDR_W-1:IDX_W]) begin
      if (xlen32_i && cnt_m)    kind_o = K_CNT_HI;
      else if (xlen32_i && hpm) kind_o = K_ZERO;
    end else if (addr_i[ADDR_W-1:IDX_W] == MEVT_BASE[ADDR_W-1:IDX_W]) begin
      if (hpm) kind_o = K_ZERO;
    end else if (addr_i == MEN_ADDR) begin
      kind_o = K_MEN;
    end else if (addr_i == SEN_ADDR) begin
      kind_o = K_SEN;
    end
  end
endmodule

// File: rtl/ctr_csr_count.sv
module ctr_csr_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             half_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HALF_W = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (wr_lo_i) begin
      if (half_i) cnt_o[HALF_W-1:0] <= wdata_i[HALF_W-1:0];
      else        cnt_o <= wdata_i;
    end else if (wr_hi_i) begin
      cnt_o[CNT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
    end else if (inc_i) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !wr_lo_i && !wr_hi_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R3
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !half_i) |=> (cnt_o == $past(wdata_i)));
endmodule

// File: rtl/ctr_csr_enables.sv
module ctr_csr_enables #(
  parameter int EN_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_m_i,
  input  logic            we_s_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] men_o,
  output logic [EN_W-1:0] sen_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      men_o <= '0;
      sen_o <= '0;
    end else begin
      if (we_m_i) men_o <= wdata_i;
      if (we_s_i) sen_o <= wdata_i;
    end
  end

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_m_i && !we_s_i) |=> ($stable(men_o) && $stable(sen_o)));
endmodule

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit
  import ctr_csr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int EN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_wdata_i,
  input  logic [1:0]        priv_i,
  input  logic              xlen32_i,
  output logic              rsp_valid_o,
  output logic [CNT_W-1:0]  rsp_rdata_o,
  output logic              rsp_illegal_o
);
  localparam int HALF_W = CNT_W / 2;

  acc_kind_e        kind;
  logic [EN_W-1:0]  men, sen;
  logic [CNT_W-1:0] cnt, rd_next;
  logic             wr, wr_lo, wr_hi, we_m, we_s;

  ctr_csr_decode #(.EN_W(EN_W)) u_dec (
    .addr_i(req_addr_i), .write_i(req_write_i), .priv_i(priv_i),
    .xlen32_i(xlen32_i), .men_i(men), .sen_i(sen), .kind_o(kind)
  );

  assign wr    = req_valid_i && req_write_i;
  assign wr_lo = wr && (kind == K_CNT_LO);
  assign wr_hi = wr && (kind == K_CNT_HI);
  assign we_m  = wr && (kind == K_MEN);
  assign we_s  = wr && (kind == K_SEN);

  ctr_csr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(retire_i), .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi), .half_i(xlen32_i), .wdata_i(req_wdata_i), .cnt_o(cnt)
  );

  ctr_csr_enables #(.EN_W(EN_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we_m_i(we_m), .we_s_i(we_s),
    .wdata_i(req_wdata_i[EN_W-1:0]), .men_o(men), .sen_o(sen)
  );

  always_comb begin
    rd_next = '0;
    case (kind)
      K_CNT_LO: rd_next = xlen32_i ? {{(CNT_W-HALF_W){1'b0}}, cnt[HALF_W-1:0]} : cnt;
      K_CNT_HI: rd_next = {{(CNT_W-HALF_W){1'b0}}, cnt[CNT_W-1:HALF_W]};
      K_MEN:    rd_next = {{(CNT_W-EN_W){1'b0}}, men};
      K_SEN:    rd_next = {{(CNT_W-EN_W){1'b0}}, sen};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o   <= 1'b0;
      rsp_rdata_o   <= '0;
      rsp_illegal_o <= 1'b0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_rdata_o   <= req_valid_i ? rd_next : '0;
      rsp_illegal_o <= req_valid_i && (kind == K_BAD);
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal_o |-> (rsp_valid_o && rsp_rdata_o == '0));

  // R10
  illegal_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && kind == K_BAD && !retire_i) |=> $stable(cnt));
endmodule

// File: tb/ctr_csr_unit_test.sv
module ctr_csr_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic [1:0]  priv_i = 2'd3;
  logic        xlen32_i = 1'b0;
  logic        rsp_valid_o;
  logic [63:0] rsp_rdata_o;
  logic        rsp_illegal_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_cnt = '0;
  logic [63:0] got_d;
  logic        got_ill;
  logic        got_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_csr_unit uut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .priv_i(priv_i), .xlen32_i(xlen32_i), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .rsp_illegal_o(rsp_illegal_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [63:0] d,
                        input logic [1:0] p, input logic ret);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    priv_i = p; retire_i = ret;
    @(negedge clk);
    got_v = rsp_valid_o; got_d = rsp_rdata_o; got_ill = rsp_illegal_o;
    req_valid_i = 1'b0; req_write_i = 1'b0; retire_i = 1'b0;
  endtask

  task automatic rd_ok(input string req, input logic [11:0] a, input logic [1:0] p,
                       input logic [63:0] exp);
    access(1'b0, a, '0, p, 1'b0);
    check(req, {63'd0, got_ill}, 64'd0);
    check(req, got_d, exp);
  endtask

  task automatic rd_bad(input string req, input logic [11:0] a, input logic [1:0] p);
    access(1'b0, a, '0, p, 1'b0);
    check(req, {63'd0, got_ill}, 64'd1);
    check(req, got_d, 64'd0);
  endtask

  task automatic t_reset();
    rd_ok("R2 reset count", 12'hB00, 2'd3, 64'd0);
    rd_ok("R9 reset men", 12'h306, 2'd3, 64'd0);
    rd_ok("R9 reset sen", 12'h106, 2'd3, 64'd0);
  endtask

  task automatic t_response();
    @(negedge clk);
    check("R1 idle no response", {63'd0, rsp_valid_o}, 64'd0);
    access(1'b0, 12'hB02, '0, 2'd3, 1'b0);
    check("R1 response valid", {63'd0, got_v}, 64'd1);
    @(negedge clk);
    check("R1 single pulse", {63'd0, rsp_valid_o}, 64'd0);
  endtask

  task automatic t_increment();
    @(negedge clk); retire_i = 1'b1;
    repeat (5) @(negedge clk);
    retire_i = 1'b0;
    exp_cnt = exp_cnt + 64'd5;
    rd_ok("R2 five retires", 12'hB00, 2'd3, exp_cnt);
    rd_ok("R5 instret alias", 12'hC02, 2'd3, exp_cnt);
    rd_ok("R5 time alias", 12'hC01, 2'd3, exp_cnt);
  endtask

  task automatic t_write_priority();
    access(1'b1, 12'hB00, 64'd100, 2'd3, 1'b1);
    exp_cnt = 64'd100;
    rd_ok("R3 write beats retire", 12'hB02, 2'd3, exp_cnt);
  endtask

  task automatic t_halves();
    access(1'b1, 12'hB02, 64'hAAAA_0000_0000_0007, 2'd3, 1'b0);
    rd_ok("R6 full write 64-bit", 12'hB00, 2'd3, 64'hAAAA_0000_0000_0007);
    xlen32_i = 1'b1;
    access(1'b1, 12'hB00, 64'hFFFF_FFFF_1234_5678, 2'd3, 1'b0);
    rd_ok("R6 low half write", 12'hB80, 2'd3, 64'h0000_0000_AAAA_0000);
    rd_ok("R5 low read 32-bit", 12'hC00, 2'd3, 64'h0000_0000_1234_5678);
    access(1'b1, 12'hB82, 64'hDEAD_0000_0000_0055, 2'd3, 1'b0);
    rd_ok("R7 high read machine", 12'hB80, 2'd3, 64'h55);
    rd_ok("R7 high read user alias", 12'hC81, 2'd3, 64'h55);
    rd_ok("R6 low kept after high write", 12'hB00, 2'd3, 64'h1234_5678);
    xlen32_i = 1'b0;
    exp_cnt = 64'h0000_0055_1234_5678;
    rd_ok("R6 combined 64-bit", 12'hB00, 2'd3, exp_cnt);
    rd_bad("R7 high in 64-bit machine", 12'hB80, 2'd3);
    rd_bad("R7 high in 64-bit user", 12'hC80, 2'd3);
  endtask

  task automatic t_gating();
    access(1'b1, 12'h306, 64'h0000_0000_FFFF_FFFF, 2'd3, 1'b0);
    rd_ok("R9 men full readback", 12'h306, 2'd3, 64'hFFFF_FFFF);
    access(1'b1, 12'h106, 64'h0000_0000_8000_0001, 2'd3, 1'b0);
    rd_ok("R9 sen readback", 12'h106, 2'd3, 64'h8000_0001);
    access(1'b1, 12'h306, 64'h5, 2'd3, 1'b0);
    access(1'b1, 12'h106, 64'h1, 2'd3, 1'b0);
    rd_ok("R4 S cycle allowed", 12'hC00, 2'd1, exp_cnt);
    rd_ok("R4 S instret allowed", 12'hC02, 2'd1, exp_cnt);
    rd_bad("R4 S time blocked", 12'hC01, 2'd1);
    rd_ok("R4 U cycle allowed", 12'hC00, 2'd0, exp_cnt);
    rd_bad("R4 U instret blocked by sen", 12'hC02, 2'd0);
    rd_bad("R4 U hpm blocked", 12'hC03, 2'd0);
    rd_ok("R4 M ignores masks", 12'hC01, 2'd3, exp_cnt);
  endtask

  task automatic t_zero();
    rd_ok("R8 mhpmcounter zero", 12'hB05, 2'd3, 64'd0);
    access(1'b1, 12'hB05, 64'h1234, 2'd3, 1'b0);
    check("R8 hpm write legal", {63'd0, got_ill}, 64'd0);
    rd_ok("R8 hpm write no effect", 12'hB00, 2'd3, exp_cnt);
    rd_ok("R8 hpm still zero", 12'hB05, 2'd3, 64'd0);
    rd_ok("R8 event zero", 12'h323, 2'd3, 64'd0);
    rd_ok("R8 user hpm zero", 12'hC1F, 2'd3, 64'd0);
    xlen32_i = 1'b1;
    rd_ok("R8 high hpm 32-bit", 12'hB9F, 2'd3, 64'd0);
    xlen32_i = 1'b0;
    rd_bad("R8 high hpm 64-bit", 12'hB9F, 2'd3);
  endtask

  task automatic t_illegal();
    rd_bad("R10 unknown address", 12'h7FF, 2'd3);
    access(1'b1, 12'hC00, 64'hFFFF, 2'd3, 1'b0);
    check("R10 user write illegal", {63'd0, got_ill}, 64'd1);
    rd_ok("R10 count unchanged", 12'hB00, 2'd3, exp_cnt);
    access(1'b1, 12'h320, 64'hFFFF, 2'd3, 1'b0);
    check("R10 write 0x320 illegal", {63'd0, got_ill}, 64'd1);
    rd_ok("R10 men unchanged", 12'h306, 2'd3, 64'h5);
    rd_bad("R10 mtime slot", 12'hB01, 2'd3);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_response();
    t_increment();
    t_write_priority();
    t_halves();
    t_gating();
    t_zero();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule